// File: doc/BRIEF.md
# Programmable Conversion Sequence Store

This block holds a short program of converter set-ups and plays it back one step per conversion. Each entry is a 6-bit configuration: a differential-pair select bit, a 3-bit input address, a bipolar-range bit and a gain bit. One pointer serves all three working phases. In the edit phase the host loads entries one by one with a write strobe, and can then read them back through a 7-bit status bus. In the run phase, every convert-start strobe applies the entry at the pointer and steps the pointer on.

The most recently written entry carries an end-of-sequence mark. During the run phase the pointer returns to the first location after that entry, so a pattern of 1 to 16 steps repeats with no host involvement. The stored program stays in place while the block sits in the direct or scan phases. On any change of the two-bit phase input the pointer goes back to location 0, so every run starts from the first step. The status bus is modelled as a data value plus an output enable instead of tri-state pads. All inputs are synchronous to `clk_i`. An edge on a strobe is acted on at the first rising clock edge that sees the new level.

Top module: `seq_cfg_sequencer`

## Requirements
- R1: After reset the pointer is at location 0, every entry and every end mark is clear, `status_oe_o` and `start_o` are low, and `cur_cfg_o` is zero.
- R2: With `mode_i` = 2'b10 and `rd_n_i` held high in both the current and the previous cycle, a rising edge of `wr_n_i` stores `cfg_i` at the pointer and advances the pointer. Field positions are: bit 5 diff, bits 4:2 address, bit 1 bipolar, bit 0 gain.
- R3: A write marks the location it writes as end of sequence and clears the mark everywhere else. A seventeenth write in one session wraps to location 0 and marks it.
- R4: With `mode_i` = 2'b10 and `wr_n_i` high, a falling edge of `rd_n_i` raises `status_oe_o` after the next clock. While the enable is high, `status_o` shows {entry[5:0], end mark} at the pointer, with the end mark at bit 0. A rising edge of `rd_n_i` drops the enable and advances the pointer. Read-back walks all 16 locations and then returns to location 0, whatever the end mark says.
- R5: With `mode_i` = 2'b11, `cur_cfg_o` shows the entry at the pointer. A falling edge of `conv_n_i` gives a one-cycle `start_o` pulse, with `start_cfg_o` holding that entry, and advances the pointer. After the marked entry the pointer returns to 0.
- R6: Any change of `mode_i` resets the pointer to 0, drops `status_oe_o`, and takes priority over a strobe edge in the same cycle.
- R7: Entries and the end mark are kept through the direct (2'b00) and scan (2'b01) phases. Returning to 2'b11 resumes at location 0.
- R8: Strobes outside their own phase change nothing. A write edge while `rd_n_i` is low stores nothing. A read edge while `wr_n_i` is low does not enable the bus. A convert edge outside 2'b11 gives no `start_o`. `cur_cfg_o` is zero outside 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Phase: 00 direct, 01 scan, 10 edit, 11 run |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| conv_n_i | input | 1 | Convert-start strobe, active on falling edge |
| cfg_i | input | 6 | Configuration to store |
| cur_cfg_o | output | 6 | Configuration applied in the run phase |
| start_o | output | 1 | One-cycle conversion start pulse |
| start_cfg_o | output | 6 | Configuration sampled with the start pulse |
| status_o | output | 7 | Read-back word {entry, end mark} |
| status_oe_o | output | 1 | Read-back bus enable |

## Verification
The bench builds the block with the default depth of 16. This makes the full read-back walk short enough to run in a few hundred cycles and keeps the seventeen-write wrap within reach. A 14-step program leaves the two top locations unwritten, so read-back past the end mark shows locations that the run phase never reaches. After the wrap test the end mark sits on location 0, which turns the run phase into a one-step loop. That loop is checked as well.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W = 3;
  localparam int CFG_W  = ADDR_W + 3;

  typedef struct packed {
    logic              diff;
    logic [ADDR_W-1:0] addr;
    logic              bip;
    logic              gain;
  } seq_cfg_t;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_EDIT   = 2'b10,
    MODE_RUN    = 2'b11
  } seq_mode_e;
endpackage

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL[b];
      else         q <= lvl_i[b];
    end
    assign prev_o[b] = q;
    assign rise_o[b] = lvl_i[b] & ~q;
    assign fall_o[b] = ~lvl_i[b] & q;
  end
endmodule

// File: rtl/seq_store.sv
module seq_store
  import seq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  seq_cfg_t         wdata_i,
  output seq_cfg_t         rdata_o,
  output logic             eos_o,
  output logic [DEPTH-1:0] eos_vec_o
);
  localparam logic [DEPTH-1:0] ONE = {{(DEPTH-1){1'b0}}, 1'b1};

  seq_cfg_t         ent_q [DEPTH];
  logic [DEPTH-1:0] eos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
      eos_q <= '0;
    end else if (we_i) begin
      ent_q[ptr_i] <= wdata_i;
      eos_q        <= ONE << ptr_i;  // newest write is the only marked entry
    end
  end

  assign rdata_o   = ent_q[ptr_i];
  assign eos_o     = eos_q[ptr_i];
  assign eos_vec_o = eos_q;
endmodule

// File: rtl/seq_ptr_ctrl.sv
module seq_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_edge_i,
  input  logic             wr_ev_i,
  input  logic             rd_fall_ev_i,
  input  logic             rd_rise_i,
  input  logic             conv_ev_i,
  input  logic             eos_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             oe_o,
  output logic             start_o
);
  logic [PTR_W-1:0] ptr_q, ptr_inc;
  logic             oe_q, start_q;

  assign ptr_inc = (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      start_q <= 1'b0;
    end else if (mode_edge_i) begin
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= conv_ev_i;
      // the three advancing events are mutually exclusive by phase
      if (wr_ev_i)                ptr_q <= ptr_inc;
      else if (rd_rise_i && oe_q) ptr_q <= ptr_inc;
      else if (conv_ev_i)         ptr_q <= eos_i ? '0 : ptr_inc;
      if (rd_fall_ev_i)           oe_q <= 1'b1;
      else if (rd_rise_i)         oe_q <= 1'b0;
    end
  end

  assign ptr_o   = ptr_q;
  assign oe_o    = oe_q;
  assign start_o = start_q;
endmodule

// File: rtl/seq_cfg_sequencer.sv
module seq_cfg_sequencer
  import seq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             wr_n_i,
  input  logic             rd_n_i,
  input  logic             conv_n_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [CFG_W-1:0] cur_cfg_o,
  output logic             start_o,
  output logic [CFG_W-1:0] start_cfg_o,
  output logic [CFG_W:0]   status_o,
  output logic             status_oe_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [1:0]       m_prev, m_rise, m_fall;
  logic [2:0]       s_prev, s_rise, s_fall;
  logic             mode_edge, in_edit, in_run;
  logic             wr_ev, rd_fall_ev, conv_ev;
  logic [PTR_W-1:0] ptr;
  logic [DEPTH-1:0] eos_vec;
  logic             eos_here, oe;
  seq_cfg_t         rdata, start_cfg_q;

  seq_edge_det #(.W(2), .RST_VAL(2'b00)) u_mode_edge (
    .clk_i, .rst_ni, .lvl_i(mode_i),
    .prev_o(m_prev), .rise_o(m_rise), .fall_o(m_fall)
  );

  // strobe order: [2] convert, [1] read, [0] write
  seq_edge_det #(.W(3), .RST_VAL(3'b111)) u_strb_edge (
    .clk_i, .rst_ni, .lvl_i({conv_n_i, rd_n_i, wr_n_i}),
    .prev_o(s_prev), .rise_o(s_rise), .fall_o(s_fall)
  );

  assign mode_edge  = |(m_rise | m_fall);
  assign in_edit    = (mode_i == MODE_EDIT);
  assign in_run     = (mode_i == MODE_RUN);
  assign wr_ev      = in_edit & s_rise[0] & rd_n_i & s_prev[1] & ~mode_edge;
  assign rd_fall_ev = in_edit & s_fall[1] & wr_n_i;
  assign conv_ev    = in_run & s_fall[2];

  seq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i, .rst_ni, .we_i(wr_ev), .ptr_i(ptr), .wdata_i(seq_cfg_t'(cfg_i)),
    .rdata_o(rdata), .eos_o(eos_here), .eos_vec_o(eos_vec)
  );

  seq_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .mode_edge_i(mode_edge), .wr_ev_i(wr_ev),
    .rd_fall_ev_i(rd_fall_ev), .rd_rise_i(s_rise[1]), .conv_ev_i(conv_ev),
    .eos_i(eos_here), .ptr_o(ptr), .oe_o(oe), .start_o(start_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     start_cfg_q <= '0;
    else if (conv_ev && !mode_edge)  start_cfg_q <= rdata;
  end

  assign start_cfg_o = start_cfg_q;
  assign cur_cfg_o   = in_run ? rdata : '0;
  assign status_oe_o = oe;
  assign status_o    = oe ? {rdata, eos_here} : '0;
endmodule

// File: rtl/seq_cfg_sequencer_chk.sv
module seq_cfg_sequencer_chk #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             rd_n_i,
  input logic             start_o,
  input logic             status_oe_o,
  input logic [DEPTH-1:0] eos_vec_i,
  input logic [PTR_W-1:0] ptr_i
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  a_r3_single_eos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(eos_vec_i));

  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r8_start_only_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && start_o) |-> ($past(mode_i) == 2'b11));

  a_r6_mode_edge_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && (mode_i != $past(mode_i))) |=> (ptr_i == '0));

  a_r4_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_oe_o && rd_n_i) |=> !status_oe_o);
endmodule

bind seq_cfg_sequencer seq_cfg_sequencer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .rd_n_i(rd_n_i),
  .start_o(start_o), .status_oe_o(status_oe_o),
  .eos_vec_i(eos_vec), .ptr_i(ptr)
);

// File: tb/seq_cfg_sequencer_bench.sv
module seq_cfg_sequencer_bench;
  localparam int N = 16;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       wr_n = 1'b1, rd_n = 1'b1, conv_n = 1'b1;
  logic [5:0] cfg = '0;
  logic [5:0] cur_cfg, start_cfg;
  logic       start, status_oe;
  logic [6:0] status;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  seq_cfg_sequencer #(.DEPTH(N)) u_seq_cfg_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_n_i(wr_n), .rd_n_i(rd_n),
    .conv_n_i(conv_n), .cfg_i(cfg), .cur_cfg_o(cur_cfg), .start_o(start),
    .start_cfg_o(start_cfg), .status_o(status), .status_oe_o(status_oe)
  );

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_mem[N];
  int m_last = -1, m_ptr = 0, m_oe = 0, m_start = 0, m_scfg = 0;
  int p_mode = 0, p_wr = 1, p_rd = 1, p_cv = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_last = -1; m_ptr = 0; m_oe = 0; m_start = 0; m_scfg = 0;
      p_mode = 0; p_wr = 1; p_rd = 1; p_cv = 1;
    end else begin
      if (int'(mode) != p_mode) begin
        m_ptr = 0; m_oe = 0; m_start = 0;
      end else begin
        m_start = 0;
        if (mode == 2'b10 && wr_n && !p_wr && rd_n && p_rd) begin
          m_mem[m_ptr] = int'(cfg); m_last = m_ptr; m_ptr = (m_ptr + 1) % N;
        end
        if (mode == 2'b10 && !rd_n && p_rd && wr_n) m_oe = 1;
        else if (rd_n && !p_rd) begin
          if (m_oe == 1) m_ptr = (m_ptr + 1) % N;
          m_oe = 0;
        end
        if (mode == 2'b11 && !conv_n && p_cv) begin
          m_start = 1; m_scfg = m_mem[m_ptr];
          m_ptr = (m_ptr == m_last) ? 0 : (m_ptr + 1) % N;
        end
      end
      p_mode = int'(mode); p_wr = int'(wr_n); p_rd = int'(rd_n); p_cv = int'(conv_n);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 status_oe vs model", int'(status_oe), m_oe);
      chk("R4 status vs model", int'(status),
          m_oe ? ((m_mem[m_ptr] << 1) | int'(m_ptr == m_last)) : 0);
      chk("R5 start vs model", int'(start), m_start);
      if (m_start == 1) chk("R5 start_cfg vs model", int'(start_cfg), m_scfg);
      chk("R8 cur_cfg vs model", int'(cur_cfg), (mode == 2'b11) ? m_mem[m_ptr] : 0);
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic set_mode(logic [1:0] m);
    @(negedge clk) mode = m;
    @(negedge clk);
  endtask

  task automatic wr_pulse(logic [5:0] v);
    @(negedge clk) begin cfg = v; wr_n = 1'b0; end
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_pulse(string tag, int exp_oe, int exp_st);
    @(negedge clk) rd_n = 1'b0;
    @(negedge clk);
    chk(tag, int'(status_oe), exp_oe);
    if (exp_oe == 1) chk(tag, int'(status), exp_st);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cv_pulse(string tag, int exp_st, int exp_cfg);
    @(negedge clk) conv_n = 1'b0;
    @(negedge clk);
    chk(tag, int'(start), exp_st);
    if (exp_st == 1) chk(tag, int'(start_cfg), exp_cfg);
    conv_n = 1'b1;
    @(negedge clk);
  endtask

  int pat[14];

  initial begin
    for (int i = 0; i < 14; i++) begin
      int a = (i % 2 == 0) ? 0 : (i / 2 + 1);
      pat[i] = (int'(i % 5 == 4) << 5) | (a << 2) | ((i % 2) << 1) | ((i / 2) % 2);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status_oe", int'(status_oe), 0);
    chk("R1 start", int'(start), 0);
    chk("R1 cur_cfg", int'(cur_cfg), 0);

    // R2: program the 14-step pattern
    set_mode(2'b10);
    foreach (pat[i]) wr_pulse(6'(pat[i]));
    set_mode(2'b11);
    set_mode(2'b10);
    // R4 R3: walk all 16 locations, then wrap to 0
    for (int l = 0; l < N; l++)
      rd_pulse("R4 readback", 1, (l < 14) ? ((pat[l] << 1) | int'(l == 13)) : 0);
    rd_pulse("R4 readback wraps to 0", 1, pat[0] << 1);

    // R5: run three loops
    set_mode(2'b11);
    chk("R5 cur_cfg first step", int'(cur_cfg), pat[0]);
    for (int k = 0; k < 42; k++) cv_pulse("R5 run step", 1, pat[k % 14]);

    // R8 R7: strobes in direct phase, then resume
    set_mode(2'b00);
    chk("R8 cur_cfg zero in direct", int'(cur_cfg), 0);
    wr_pulse(6'h3f);
    rd_pulse("R8 no read in direct", 0, 0);
    cv_pulse("R8 no start in direct", 0, 0);
    set_mode(2'b01);
    cv_pulse("R8 no start in scan", 0, 0);
    set_mode(2'b11);
    chk("R7 resume at location 0", int'(cur_cfg), pat[0]);
    cv_pulse("R7 resumed step 0", 1, pat[0]);
    cv_pulse("R7 resumed step 1", 1, pat[1]);
    cv_pulse("R6 convert in run", 1, pat[2]);
    set_mode(2'b10);
    set_mode(2'b11);
    chk("R6 mode edge resets pointer", int'(cur_cfg), pat[0]);

    // R8: write edge with read low stores nothing
    set_mode(2'b10);
    @(negedge clk) rd_n = 1'b0;
    wr_pulse(6'h2a);
    @(negedge clk) rd_n = 1'b1;
    @(negedge clk);
    set_mode(2'b11);
    set_mode(2'b10);
    rd_pulse("R8 write with read low ignored", 1, pat[0] << 1);
    // R8: read edge with write low does not enable the bus
    @(negedge clk) wr_n = 1'b0;
    rd_pulse("R8 read with write low ignored", 0, 0);
    @(negedge clk) wr_n = 1'b1;
    @(negedge clk);

    // R3: seventeen writes wrap and mark location 0
    set_mode(2'b11);
    set_mode(2'b10);
    for (int i = 0; i < 17; i++) wr_pulse(6'(i + 5));
    set_mode(2'b11);
    set_mode(2'b10);
    rd_pulse("R3 wrap entry marked", 1, (21 << 1) | 1);
    rd_pulse("R3 earlier entry unmarked", 1, 6 << 1);
    set_mode(2'b11);
    cv_pulse("R3 one-step loop", 1, 21);
    cv_pulse("R3 one-step loop repeats", 1, 21);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule